// File: doc/BRIEF.md
# Startup Sequencer with Option Loading

This block brings a small processor core out of reset in a fixed order. The external reset pin is active low. The block asserts its internal reset at once when the pin goes low, and releases it in step with the oscillator clock. After the release it counts a programmable stability interval so the oscillator can settle. It then opens a fetch window of a fixed number of oscillator cycles. In that window it reads the configuration words from a small non-volatile option store into option registers. At the end of the window it pulses a program-counter load with a start address of zero, and it holds the run enable high until the next reset.

The option store sits outside the block. It is read through a synchronous port: the block drives an address and a read strobe, and the data comes back on the following clock. The option registers present their reset defaults until each word has been captured.

Top module: `boot_sequencer`

## Requirements
- R1: While the reset pin is low, `run_en`, `pc_load` and `opt_rd_en` are low. `opt_bits` shows `OPT_DEFAULT` immediately, without waiting for a clock edge.
- R2: The pin release passes through two synchronizing flops. The stability wait then lasts `STAB_CYCLES` cycles. The first option read is therefore visible after clock edge `STAB_CYCLES+2`, counting edges from the release.
- R3: The fetch window lasts exactly `LOAD_CYCLES` cycles (512 by default). `pc_load` is therefore first high after edge `STAB_CYCLES+LOAD_CYCLES+2`.
- R4: Each fetch window issues exactly `OPT_WORDS` reads, one per cycle, at the start of the window. The addresses run upward from 0. No read happens outside the window.
- R5: A word read at address i is captured on the cycle after the data returns, into `opt_bits[i*OPT_WIDTH +: OPT_WIDTH]`.
- R6: `pc_load` is high for exactly one cycle, and `pc_start_addr` is zero while it is high. `run_en` rises together with `pc_load` and stays high until reset.
- R7: A reset at any point aborts the sequence and restores the defaults. The next release repeats the full sequence and loads fresh contents.
- R8: `opt_bits` changes only on a capture. It holds `OPT_DEFAULT` through the stability wait and holds the loaded values while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_pin_n | input | 1 | Active-low external reset pin |
| opt_rd_en | output | 1 | Read strobe to the option store |
| opt_addr | output | AW | Option word address |
| opt_rd_data | input | OPT_WIDTH | Word returned one cycle after the strobe |
| opt_bits | output | OPT_WORDS*OPT_WIDTH | Option register contents, word i at bits i*OPT_WIDTH |
| pc_load | output | 1 | One-cycle program-counter load strobe |
| pc_start_addr | output | PC_W | Start address applied with `pc_load` (zero) |
| run_en | output | 1 | Core execution enable |

## Verification
A phase or counter error shows at the ports as a wrong cycle count, either to the first option read or to `pc_load`. The bench measures both counts exactly on every release, so an error is reported within the same startup sequence. A wrong read address or capture index leaves a misplaced field in `opt_bits`. That error is visible as soon as `pc_load` fires. A failed abort leaves `run_en` high or leaves loaded values in `opt_bits` one time step after the pin falls, and the bench checks both at that point.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [1:0] {
    PH_SETTLE = 2'd0,
    PH_FETCH  = 2'd1,
    PH_LAUNCH = 2'd2,
    PH_RUN    = 2'd3
  } boot_phase_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bs_rst_sync.sv
module bs_rst_sync (
  input  logic clk,
  input  logic pin_n,
  output logic rst_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge pin_n) begin
    if (!pin_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n = sync_q;

endmodule

// File: rtl/bs_ctrl.sv
module bs_ctrl
  import boot_seq_pkg::*;
#(
  parameter int STAB_CYCLES = 16384,
  parameter int LOAD_CYCLES = 512,
  parameter int OPT_WORDS   = 4,
  localparam int AW = (OPT_WORDS > 1) ? $clog2(OPT_WORDS) : 1,
  localparam int CW = $clog2(max_of(max_of(STAB_CYCLES, LOAD_CYCLES), OPT_WORDS) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          rd_en,
  output logic [AW-1:0] rd_idx,
  output logic          pc_load,
  output logic          run_en
);

  boot_phase_e   phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // next-state process
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_SETTLE: begin
        if (cnt_q == CW'(STAB_CYCLES - 1)) begin
          phase_d = PH_FETCH;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_FETCH: begin
        if (cnt_q == CW'(LOAD_CYCLES - 1)) begin
          phase_d = PH_LAUNCH;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_LAUNCH: phase_d = PH_RUN;
      PH_RUN:    phase_d = PH_RUN;
      default:   phase_d = PH_SETTLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SETTLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign rd_en   = (phase_q == PH_FETCH) && (cnt_q < CW'(OPT_WORDS));
  assign rd_idx  = cnt_q[AW-1:0];
  assign pc_load = (phase_q == PH_LAUNCH);
  assign run_en  = (phase_q == PH_LAUNCH) || (phase_q == PH_RUN);

  // R3: launch follows the last fetch cycle
  p_launch_after_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LAUNCH) |-> ($past(phase_q) == PH_FETCH && $past(cnt_q) == CW'(LOAD_CYCLES - 1)));

  // R6: single-cycle load strobe, execution enabled after it
  p_pc_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> (!pc_load && run_en));

  // R6: run enable held until reset
  p_run_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> run_en);

  // R2: no read during the stability wait
  p_no_read_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SETTLE) |-> !rd_en);

endmodule

// File: rtl/bs_opt_loader.sv
module bs_opt_loader #(
  parameter int OPT_WORDS = 4,
  parameter int OPT_WIDTH = 8,
  parameter logic [OPT_WORDS*OPT_WIDTH-1:0] OPT_DEFAULT = '0,
  localparam int AW = (OPT_WORDS > 1) ? $clog2(OPT_WORDS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rd_en,
  input  logic [AW-1:0]                  rd_idx,
  input  logic [OPT_WIDTH-1:0]           rd_data,
  output logic [OPT_WORDS*OPT_WIDTH-1:0] opt_bits
);

  logic          cap_vld_q;
  logic [AW-1:0] cap_idx_q;

  // data returns one cycle after the strobe; remember where it belongs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vld_q <= 1'b0;
      cap_idx_q <= '0;
    end else begin
      cap_vld_q <= rd_en;
      if (rd_en) begin
        cap_idx_q <= rd_idx;
      end
    end
  end

  for (genvar w = 0; w < OPT_WORDS; w++) begin : g_word
    logic                 wr_en;
    logic [OPT_WIDTH-1:0] word_q;

    assign wr_en = cap_vld_q && (cap_idx_q == AW'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= OPT_DEFAULT[w*OPT_WIDTH +: OPT_WIDTH];
      end else if (wr_en) begin
        word_q <= rd_data;
      end
    end

    assign opt_bits[w*OPT_WIDTH +: OPT_WIDTH] = word_q;
  end

  // R8: option registers move only on a capture
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_vld_q |=> $stable(opt_bits));

endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer #(
  parameter int STAB_CYCLES = 16384,
  parameter int LOAD_CYCLES = 512,
  parameter int OPT_WORDS   = 4,
  parameter int OPT_WIDTH   = 8,
  parameter int PC_W        = 12,
  parameter logic [OPT_WORDS*OPT_WIDTH-1:0] OPT_DEFAULT = '0,
  localparam int AW = (OPT_WORDS > 1) ? $clog2(OPT_WORDS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_pin_n,
  output logic                           opt_rd_en,
  output logic [AW-1:0]                  opt_addr,
  input  logic [OPT_WIDTH-1:0]           opt_rd_data,
  output logic [OPT_WORDS*OPT_WIDTH-1:0] opt_bits,
  output logic                           pc_load,
  output logic [PC_W-1:0]                pc_start_addr,
  output logic                           run_en
);

  logic rst_sync_n;

  bs_rst_sync i_sync (
    .clk   (clk),
    .pin_n (rst_pin_n),
    .rst_n (rst_sync_n)
  );

  bs_ctrl #(
    .STAB_CYCLES (STAB_CYCLES),
    .LOAD_CYCLES (LOAD_CYCLES),
    .OPT_WORDS   (OPT_WORDS)
  ) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_en   (opt_rd_en),
    .rd_idx  (opt_addr),
    .pc_load (pc_load),
    .run_en  (run_en)
  );

  bs_opt_loader #(
    .OPT_WORDS   (OPT_WORDS),
    .OPT_WIDTH   (OPT_WIDTH),
    .OPT_DEFAULT (OPT_DEFAULT)
  ) i_loader (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_en    (opt_rd_en),
    .rd_idx   (opt_addr),
    .rd_data  (opt_rd_data),
    .opt_bits (opt_bits)
  );

  assign pc_start_addr = '0;

  // R4: consecutive reads step the address by one
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (opt_rd_en && $past(opt_rd_en)) |-> (opt_addr == $past(opt_addr) + 1'b1));

  // R4: no read once the core is running
  p_no_read_running_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    run_en |-> !opt_rd_en);

endmodule

// File: tb/test_boot_sequencer.sv
module test_boot_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int STAB  = 37;
  localparam int LOADC = 512;
  localparam int NW    = 6;
  localparam int WW    = 8;
  localparam int AW    = 3;
  localparam logic [NW*WW-1:0] DEF = 48'h5A5A_C3C3_0F0F;

  logic              clk;
  logic              rst_pin_n;
  logic              opt_rd_en;
  logic [AW-1:0]     opt_addr;
  logic [WW-1:0]     opt_rd_data;
  logic [NW*WW-1:0]  opt_bits;
  logic              pc_load;
  logic [11:0]       pc_start_addr;
  logic              run_en;

  logic [WW-1:0] mem [NW];
  int total;
  int bad;
  bit done;

  boot_sequencer #(
    .STAB_CYCLES (STAB),
    .LOAD_CYCLES (LOADC),
    .OPT_WORDS   (NW),
    .OPT_WIDTH   (WW),
    .PC_W        (12),
    .OPT_DEFAULT (DEF)
  ) i_boot_sequencer (
    .clk           (clk),
    .rst_pin_n     (rst_pin_n),
    .opt_rd_en     (opt_rd_en),
    .opt_addr      (opt_addr),
    .opt_rd_data   (opt_rd_data),
    .opt_bits      (opt_bits),
    .pc_load       (pc_load),
    .pc_start_addr (pc_start_addr),
    .run_en        (run_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // option store model: synchronous read
  always @(posedge clk) begin
    if (opt_rd_en) opt_rd_data <= mem[opt_addr];
  end

  function automatic logic [NW*WW-1:0] pack_mem();
    logic [NW*WW-1:0] v;
    for (int i = 0; i < NW; i++) v[i*WW +: WW] = mem[i];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // R1: reset state, with the pin held low for a few cycles
  task automatic hold_reset(input int n);
    rst_pin_n = 1'b0;
    #1;
    chk(opt_bits == DEF, "R1", "opt_bits async default", 64'(opt_bits), 64'(DEF));
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
    chk(!run_en && !pc_load && !opt_rd_en, "R1", "outputs quiet in reset",
        {61'd0, run_en, pc_load, opt_rd_en}, 64'd0);
  endtask

  // one release; abort_k > 0 pulls the pin low after edge abort_k
  task automatic sequence_run(input int abort_k);
    int k;
    int nreads;
    int first_rd;
    int launch_k;
    bit addr_ok;
    bit quiet_ok;
    logic [NW*WW-1:0] exp;
    for (int i = 0; i < NW; i++) mem[i] = WW'($urandom);
    exp = pack_mem();
    hold_reset(3);
    rst_pin_n = 1'b1;
    k = 0; nreads = 0; first_rd = -1; launch_k = -1;
    addr_ok = 1'b1; quiet_ok = 1'b1;
    while (launch_k < 0 && k < STAB + LOADC + 10) begin
      @(posedge clk); #1; k++;
      if (opt_rd_en) begin
        if (first_rd < 0) first_rd = k;
        if (opt_addr != AW'(nreads)) addr_ok = 1'b0;
        nreads++;
      end
      if (k == STAB + 2)
        chk(opt_bits == DEF, "R8", "defaults held during wait", 64'(opt_bits), 64'(DEF));
      if (pc_load) launch_k = k;
      else if (run_en) quiet_ok = 1'b0;
      if (abort_k > 0 && k == abort_k) begin
        rst_pin_n = 1'b0;
        #1;
        chk(opt_bits == DEF && !run_en && !pc_load && !opt_rd_en, "R7",
            "abort restores defaults", 64'(opt_bits), 64'(DEF));
        return;
      end
    end
    chk(first_rd == STAB + 2, "R2", "edge of first read", 64'(first_rd), 64'(STAB + 2));
    chk(launch_k == STAB + LOADC + 2, "R3", "edge of pc_load", 64'(launch_k),
        64'(STAB + LOADC + 2));
    chk(nreads == NW && addr_ok, "R4", "read count/ascending addr", 64'(nreads), 64'(NW));
    chk(opt_bits == exp, "R5", "loaded option bits", 64'(opt_bits), 64'(exp));
    chk(run_en && quiet_ok && pc_start_addr == '0, "R6", "run_en rises with pc_load to 0",
        {62'd0, run_en, quiet_ok}, 64'd3);
    begin
      int hold;
      bit hold_ok;
      hold = 10 + int'($urandom % 30);
      hold_ok = 1'b1;
      for (int i = 0; i < hold; i++) begin
        @(posedge clk); #1;
        if (pc_load || !run_en || opt_rd_en) hold_ok = 1'b0;
        if (opt_bits != exp) hold_ok = 1'b0;
      end
      chk(hold_ok, "R6", "single pulse, run_en held", {63'd0, hold_ok}, 64'd1);
      chk(opt_bits == exp, "R8", "options stable while running", 64'(opt_bits), 64'(exp));
    end
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_pin_n = 1'b0;
    void'($urandom(32'd4242));
    @(posedge clk); #1;
    // directed aborts: during sync, wait, reads, mid window, at launch
    sequence_run(1);
    sequence_run(20);
    sequence_run(STAB + 4);
    sequence_run(STAB + 300);
    sequence_run(STAB + LOADC + 2);
    // R7: full sequence after an abort loads fresh contents
    sequence_run(0);
    for (int t = 0; t < 10; t++) begin
      if (($urandom % 10) < 3) sequence_run(1 + int'($urandom % (STAB + LOADC + 2)));
      else sequence_run(0);
    end
    hold_reset(2);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

endmodule